// File: doc/BRIEF.md
# Per-Sector Write Lockdown Controller

This block keeps one volatile lockdown flag per sector of a flash-style memory model and decides whether each program or erase request may go ahead. An upstream command decoder reports each bus cycle of a lockdown command sequence with `cmd_beat`. It marks the final cycle with `lock_done` and the sector index. The flag for that sector is set only when the final cycle follows exactly the required number of earlier cycles. No command can clear a flag. Only reset returns every sector to the unlocked state.

A program or erase aimed at a locked sector is refused. The refusal puts the block into a status-read state. Reads then return a status word with the failure bit set, and that bit stays set until an identification-exit strobe arrives. While identification mode is active, software can read a sector's lock state at word offset 2h of that sector. Array storage and programming timing are handled elsewhere. Normal reads pass the array data through.

Top module: `lkd_ctrl`

## Requirements
- R1: After reset every sector is unlocked: lock readback returns 0000h for every sector, `err` is 0, and a request to any sector is granted.
- R2: A lock takes effect only when `lock_done` arrives after exactly five `cmd_beat` pulses counted since the last `lock_done`, abort or reset, which makes six bus cycles in total. A `lock_done` after any other count changes no flag.
- R3: A flag that has been set stays set through lock commands, identification exits and requests. Only reset clears it.
- R4: In the cycle after a program or erase request, exactly one of `op_grant` and `op_deny` is high. Deny is chosen when the sector in the top `SECT_W` bits of `op_addr` is locked. With no request, both outputs are low.
- R5: A denied request sets `err` in the same cycle as `op_deny`. While `err` is 1, every read returns the status word 0020h, which is failure bit 5 alone.
- R6: `err` stays 1 until `id_exit` is pulsed, and it is 0 in the cycle after that pulse. If a denial occurs in the same cycle as `id_exit`, the denial wins and `err` stays 1.
- R7: Granted requests never set `err`, so it reads 0 while operations are being accepted.
- R8: In identification mode with `err` clear, a read at word offset 2h, given by the low `ADDR_W-SECT_W` address bits, returns that sector's flag on bit 0 (1 means locked) with every other bit 0.
- R9: A complete lock sequence aimed at a sector that is already locked leaves all flags unchanged and does not set `err`.
- R10: Reads outside status and lock-readback cases return `array_rdata` when identification mode is off. In identification mode they return 0000h.
- R11: `cmd_abort` discards the beats counted so far, so a sequence that is restarted must supply five fresh beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all flags |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Read word address |
| array_rdata | input | DATA_W | Data from the array for normal reads |
| id_mode | input | 1 | Identification mode active |
| id_exit | input | 1 | Identification-exit command strobe |
| cmd_beat | input | 1 | One bus cycle of a lockdown sequence |
| cmd_abort | input | 1 | Sequence abandoned by the decoder |
| lock_done | input | 1 | Final cycle of a lockdown sequence |
| lock_sector | input | SECT_W | Sector named by the lockdown sequence |
| prog_req | input | 1 | Program request strobe |
| erase_req | input | 1 | Erase request strobe |
| op_addr | input | ADDR_W | Target address of the request |
| op_grant | output | 1 | Request accepted (one cycle after it) |
| op_deny | output | 1 | Request refused (one cycle after it) |
| err | output | 1 | Sticky failure status |
| rdata | output | DATA_W | Registered read data |

## Verification
On every cycle, the assertions check that each request receives exactly one response and that no response appears without a request. They also check that a denial raises `err`, that `err` only rises with a denial and holds until an exit, and that lock flags only ever gain bits, one sector at a time. The bench scenarios are needed to show that these rules are applied correctly. Those scenarios cover the six-cycle counting rule, the abort behaviour, the mapping of sectors to readback addresses, the contents of the status word and the lock-readback word, and the fact that only reset unlocks a sector.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_LOCK   = 2'd1,
    RD_STATUS = 2'd2,
    RD_ZERO   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/lkd_beat_counter.sv
module lkd_beat_counter #(
  parameter int LOCK_BEATS = 6,
  localparam int CNT_W = $clog2(LOCK_BEATS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_beat,
  input  logic cmd_abort,
  input  logic lock_done,
  output logic lock_accept
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(LOCK_BEATS)) ? c : c + 1'b1;
  endfunction

  assign lock_accept = lock_done && (cnt_q == CNT_W'(LOCK_BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (lock_done || cmd_abort) cnt_q <= '0;
    else if (cmd_beat)               cnt_q <= next_cnt(cnt_q);
  end
endmodule

// File: rtl/lkd_flag_bank.sv
module lkd_flag_bank #(
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SECT_W-1:0] set_sect,
  output logic [NSECT-1:0]  lock_vec
);
  for (genvar g = 0; g < NSECT; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    lock_vec[g] <= 1'b0;
      else if (set_en && (set_sect == SECT_W'(g)))   lock_vec[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/lkd_gate.sv
module lkd_gate #(
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_req,
  input  logic [SECT_W-1:0] req_sect,
  input  logic [NSECT-1:0]  lock_vec,
  input  logic              id_exit,
  output logic              deny_evt,
  output logic              op_grant,
  output logic              op_deny,
  output logic              fail_q
);
  assign deny_evt = any_req && lock_vec[req_sect];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_grant <= 1'b0;
      op_deny  <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      op_grant <= any_req && !deny_evt;
      op_deny  <= deny_evt;
      if (deny_evt)     fail_q <= 1'b1;
      else if (id_exit) fail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lkd_readback.sv
module lkd_readback
  import lkd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 3,
  parameter int LOCK_OFF = 2,
  parameter int FAIL_BIT = 5,
  localparam int NSECT = 1 << SECT_W,
  localparam int OFF_W = ADDR_W - SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              id_mode,
  input  logic              fail_q,
  input  logic [NSECT-1:0]  lock_vec,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  rd_src_e src;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if (fail_q)                                        src = RD_STATUS;
    else if (id_mode && off_of(bus_addr) == OFF_W'(LOCK_OFF)) src = RD_LOCK;
    else if (id_mode)                                  src = RD_ZERO;
    else                                               src = RD_ARRAY;
  end

  always_comb begin
    rd_next = '0;
    unique case (src)
      RD_STATUS: rd_next[FAIL_BIT] = 1'b1;
      RD_LOCK:   rd_next[0] = lock_vec[sect_of(bus_addr)];
      RD_ZERO:   rd_next = '0;
      RD_ARRAY:  rd_next = array_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (bus_rd) rdata <= rd_next;
  end
endmodule

// File: rtl/lkd_ctrl.sv
module lkd_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SECT_W     = 3,
  parameter int LOCK_BEATS = 6,
  parameter int LOCK_OFF   = 2,
  parameter int FAIL_BIT   = 5,
  localparam int NSECT = 1 << SECT_W,
  localparam int OFF_W = ADDR_W - SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              id_mode,
  input  logic              id_exit,
  input  logic              cmd_beat,
  input  logic              cmd_abort,
  input  logic              lock_done,
  input  logic [SECT_W-1:0] lock_sector,
  input  logic              prog_req,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_grant,
  output logic              op_deny,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  logic              lock_accept;
  logic [NSECT-1:0]  lock_vec;
  logic              any_req;
  logic              deny_evt;
  logic              fail_q;
  logic [SECT_W-1:0] req_sect;
  logic              unused_off;

  assign any_req    = prog_req || erase_req;
  assign req_sect   = op_addr[ADDR_W-1 -: SECT_W];
  assign unused_off = ^op_addr[OFF_W-1:0];
  assign err        = fail_q;

  lkd_beat_counter #(.LOCK_BEATS(LOCK_BEATS)) u_beats (
    .clk(clk), .rst_n(rst_n), .cmd_beat(cmd_beat), .cmd_abort(cmd_abort),
    .lock_done(lock_done), .lock_accept(lock_accept)
  );

  lkd_flag_bank #(.SECT_W(SECT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(lock_accept), .set_sect(lock_sector),
    .lock_vec(lock_vec)
  );

  lkd_gate #(.SECT_W(SECT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .req_sect(req_sect),
    .lock_vec(lock_vec), .id_exit(id_exit), .deny_evt(deny_evt),
    .op_grant(op_grant), .op_deny(op_deny), .fail_q(fail_q)
  );

  lkd_readback #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .LOCK_OFF(LOCK_OFF), .FAIL_BIT(FAIL_BIT)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .array_rdata(array_rdata), .id_mode(id_mode), .fail_q(fail_q),
    .lock_vec(lock_vec), .rdata(rdata)
  );
endmodule

// File: rtl/lkd_ctrl_chk.sv
module lkd_ctrl_chk #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             any_req,
  input logic             deny_evt,
  input logic             id_exit,
  input logic             op_grant,
  input logic             op_deny,
  input logic             err,
  input logic [NSECT-1:0] lock_vec
);
  AST_REQ_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> (op_grant != op_deny)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (!op_grant && !op_deny)); // R4
  AST_DENY_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    op_deny |-> err); // R5
  AST_ERR_ONLY_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> op_deny); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !id_exit) |=> err); // R6
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (id_exit && !deny_evt) |=> !err); // R6
  AST_FLAGS_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec != '0) |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec))); // R3
  AST_ONE_FLAG_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_vec) != NSECT |=> $countones(lock_vec ^ $past(lock_vec)) <= 1); // R2
endmodule

bind lkd_ctrl lkd_ctrl_chk #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .any_req(any_req), .deny_evt(deny_evt),
  .id_exit(id_exit), .op_grant(op_grant), .op_deny(op_deny), .err(err),
  .lock_vec(lock_vec)
);

// File: tb/test_lkd_ctrl.sv
`timescale 1ns/1ps
module test_lkd_ctrl;
  localparam int ADDR_W = 16, DATA_W = 16, SECT_W = 3;
  localparam int OFF_W  = ADDR_W - SECT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_rd = 0, id_mode = 0, id_exit = 0, cmd_beat = 0, cmd_abort = 0;
  logic lock_done = 0, prog_req = 0, erase_req = 0;
  logic [ADDR_W-1:0] bus_addr = '0, op_addr = '0;
  logic [DATA_W-1:0] array_rdata = 16'hA5C3;
  logic [SECT_W-1:0] lock_sector = '0;
  logic op_grant, op_deny, err;
  logic [DATA_W-1:0] rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lkd_ctrl i_lkd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .array_rdata(array_rdata), .id_mode(id_mode), .id_exit(id_exit),
    .cmd_beat(cmd_beat), .cmd_abort(cmd_abort), .lock_done(lock_done),
    .lock_sector(lock_sector), .prog_req(prog_req), .erase_req(erase_req),
    .op_addr(op_addr), .op_grant(op_grant), .op_deny(op_deny), .err(err),
    .rdata(rdata)
  );

  // {erase, address[15:0], expect_deny}; sectors 1 and 6 are locked beforehand
  localparam logic [17:0] VEC [0:7] = '{
    {1'b0, 16'h0010, 1'b0}, {1'b0, 16'h2000, 1'b1},
    {1'b1, 16'h4123, 1'b0}, {1'b0, 16'h6002, 1'b0},
    {1'b1, 16'h8000, 1'b0}, {1'b0, 16'hA7FF, 1'b0},
    {1'b1, 16'hC004, 1'b1}, {1'b0, 16'hFFFF, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] saddr(input int s, input int off);
    return {SECT_W'(s), OFF_W'(off)};
  endfunction

  task automatic lock_seq(input int s, input int beats);
    for (int i = 0; i < beats; i++) begin
      @(negedge clk); cmd_beat = 1;
      @(negedge clk); cmd_beat = 0;
    end
    @(negedge clk); lock_done = 1; lock_sector = SECT_W'(s);
    @(negedge clk); lock_done = 0;
  endtask

  task automatic do_op(input logic er, input logic [ADDR_W-1:0] a, input logic xit,
                       output logic g, output logic d);
    @(negedge clk);
    prog_req = !er; erase_req = er; op_addr = a; id_exit = xit;
    @(negedge clk);
    prog_req = 0; erase_req = 0; id_exit = 0;
    g = op_grant; d = op_deny;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = rdata;
  endtask

  task automatic pulse_exit();
    @(negedge clk); id_exit = 1;
    @(negedge clk); id_exit = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic g, d;
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 err after reset", err, 0);
    check("R1 grant idle", op_grant, 0);
    check("R4 deny idle", op_deny, 0);
    id_mode = 1;
    for (int s = 0; s < 8; s++) begin
      do_read(saddr(s, 2), rd);
      check("R1 R8 unlocked readback", rd, 16'h0000);
    end
    id_mode = 0;

    do_op(0, saddr(1, 5), 0, g, d);
    check("R1 grant after reset", {g, d}, 2'b10);
    check("R7 err stays clear on grant", err, 0);

    lock_seq(1, 5);
    lock_seq(6, 5);
    lock_seq(3, 4);                  // R2 short sequence ignored
    lock_seq(2, 6);                  // R2 long sequence ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cmd_beat = 1;
      @(negedge clk); cmd_beat = 0;
    end
    @(negedge clk); cmd_abort = 1;
    @(negedge clk); cmd_abort = 0;
    lock_seq(4, 2);                  // R11 only two fresh beats after abort
    check("R7 err clear after locking", err, 0);

    for (int i = 0; i < 8; i++) begin
      do_op(VEC[i][17], VEC[i][16:1], 0, g, d);
      check("R4 table grant/deny", {g, d}, VEC[i][0] ? 2'b01 : 2'b10);
      if (i == 1) check("R5 err with deny", err, 1);
    end
    check("R5 err after table", err, 1);
    do_read(saddr(3, 7), rd);
    check("R5 status word", rd, 16'h0020);
    id_mode = 1;
    do_read(saddr(0, 2), rd);
    check("R5 status over id readback", rd, 16'h0020);
    id_mode = 0;
    repeat (5) @(negedge clk);
    check("R6 err sticky", err, 1);
    pulse_exit();
    check("R6 err cleared by exit", err, 0);
    do_read(saddr(5, 9), rd);
    check("R10 array passthrough", rd, 16'hA5C3);

    id_mode = 1;
    do_read(saddr(1, 2), rd);  check("R8 sector1 locked", rd, 16'h0001);
    do_read(saddr(6, 2), rd);  check("R8 sector6 locked", rd, 16'h0001);
    do_read(saddr(3, 2), rd);  check("R2 short seq no lock", rd, 16'h0000);
    do_read(saddr(2, 2), rd);  check("R2 long seq no lock", rd, 16'h0000);
    do_read(saddr(4, 2), rd);  check("R11 abort discards beats", rd, 16'h0000);
    do_read(saddr(1, 5), rd);  check("R10 id other offset zero", rd, 16'h0000);
    id_mode = 0;

    lock_seq(1, 5);
    check("R9 relock no error", err, 0);
    pulse_exit();
    id_mode = 1;
    do_read(saddr(1, 2), rd);  check("R3 flag survives exit and relock", rd, 16'h0001);
    do_read(saddr(0, 2), rd);  check("R9 relock leaves others", rd, 16'h0000);
    id_mode = 0;

    do_op(0, saddr(6, 1), 1, g, d);
    check("R6 deny beats same-cycle exit", err, 1);
    check("R4 deny with exit", {g, d}, 2'b01);
    pulse_exit();
    check("R6 exit after collision", err, 0);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    id_mode = 1;
    do_read(saddr(1, 2), rd);  check("R3 reset unlocks", rd, 16'h0000);
    id_mode = 0;
    do_op(1, saddr(6, 0), 0, g, d);
    check("R1 grant after second reset", {g, d}, 2'b10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule